// File: doc/BRIEF.md
# Pipelined CORDIC Sine and Cosine Generator

This block turns a fixed-point angle in radians into its sine and cosine using a fully unrolled CORDIC pipeline, one micro-rotation per register stage. On every enabled clock edge it takes one angle, and a matching sine/cosine pair appears a fixed number of enabled edges later. A valid flag travels with each sample, so back-to-back angles and gaps in the input stream are both handled.

A build-time switch picks one of two operating modes. Full-circle mode takes a two's complement angle anywhere in [-π, +π] and gives signed results. First-quadrant mode takes an unsigned angle in [0, π/2] and gives unsigned results with one bit fewer. In full-circle mode, angles outside ±π/2 are moved by ±π into the convergence range and both results are negated at the end. The vector starts at the reciprocal of the CORDIC gain, so no gain multiplier is needed at the output. Input and output fraction widths are parameters. The output fraction must not be wider than the input fraction.

A clock-enable input freezes every register of the pipeline while it is low. An asynchronous reset clears the pipeline.

Top module: `sincos_cordic`

## Requirements
- R1: While the asynchronous reset is asserted, `resultValid`, `sinOut` and `cosOut` are all zero.
- R2: With `SIGNED_MODE=1`, `angleIn` is a two's complement value of FIN+3 bits with FIN fraction bits, covering [-π, +π]. `sinOut` and `cosOut` are two's complement values of FOUT+2 bits whose real value is code/2^FOUT.
- R3: With `SIGNED_MODE=0`, `angleIn` is an unsigned value of FIN+1 bits with FIN fraction bits, covering [0, π/2]. `sinOut` and `cosOut` are unsigned values of FOUT+1 bits whose real value is code/2^FOUT.
- R4: Each result differs from the exact sine or cosine of the applied angle code by no more than one unit of 2^-FOUT (faithful rounding).
- R5: In full-circle mode, angles with magnitude above π/2, up to and including ±π, give results with the correct sign in every quadrant.
- R6: A sample taken with `angleValid` high on an enabled edge comes out with `resultValid` high exactly FOUT+5 enabled edges later. One new sample is accepted on each enabled edge, and samples leave in the order they entered.
- R7: While `clkEn` is low, `resultValid`, `sinOut` and `cosOut` hold their values and no input is taken.
- R8: Result magnitudes never go above 1.0 (code 2^FOUT). In first-quadrant mode, results are never below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst | input | 1 | Asynchronous reset, active high |
| clkEn | input | 1 | Clock enable; low stalls the whole pipeline (ignored when USE_EN=0) |
| angleIn | input | FIN+3 (signed) or FIN+1 (unsigned) | Angle in radians, FIN fraction bits |
| angleValid | input | 1 | Marks `angleIn` as a sample |
| sinOut | output | FOUT+2 (signed) or FOUT+1 (unsigned) | Sine, FOUT fraction bits |
| cosOut | output | FOUT+2 (signed) or FOUT+1 (unsigned) | Cosine, FOUT fraction bits |
| resultValid | output | 1 | Marks `sinOut`/`cosOut` as a result |

## Verification
The bench drives the fold thresholds ±π/2 and the codes just inside and just outside them, plus ±π and zero. A design with a wrong fold comparison or a missing output negation would give results of the wrong sign or magnitude there. The codes nearest ±π/2 and 0 push one result to exactly ±1.0, which catches missing saturation or an off-by-one in the rounding offset. Random enable gaps with a mix of valid and idle samples catch stages that keep advancing during a stall, or a valid flag that drifts out of step with its data. A dense sweep over the full range on both a full-circle and a first-quadrant instance catches a wrong arctangent constant, shift amount or guard width, because these show up as errors larger than one unit.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic adv;   // advance every pipeline register this cycle
  } ctrl_t;

  localparam real PI_R   = 3.141592653589793;
  localparam real INVK_R = 0.6072529350088813;

  // Real value scaled by 2^fb and rounded to the nearest integer
  function automatic logic signed [63:0] toFix(input real v, input int fb);
    real sc;
    sc = 1.0;
    for (int k = 0; k < fb; k++) sc = sc * 2.0;
    return longint'(v * sc);
  endfunction

  // atan(2^-i) by series expansion (argument at most 0.5 for i >= 1)
  function automatic real atanPow2(input int i);
    real t, s, p, sg;
    if (i == 0) return PI_R / 4.0;
    t = 1.0;
    for (int k = 0; k < i; k++) t = t / 2.0;
    s  = 0.0;
    p  = t;
    sg = 1.0;
    for (int k = 0; k < 40; k++) begin
      s  = s + sg * p / real'(2 * k + 1);
      p  = p * t * t;
      sg = -sg;
    end
    return s;
  endfunction

endpackage

// File: rtl/sincos_ctrl.sv
module sincos_ctrl
  import sincos_pkg::*;
#(
  parameter int LAT    = 15,
  parameter bit USE_EN = 1'b1
) (
  input  logic  clk,
  input  logic  arst,
  input  logic  clkEn,
  input  logic  validIn,
  output ctrl_t ctrl,
  output logic  validOut
);

  logic [LAT-1:0] validPipe;

  always_comb begin
    ctrl.adv = USE_EN ? clkEn : 1'b1;
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst)          validPipe <= '0;
    else if (ctrl.adv) validPipe <= {validPipe[LAT-2:0], validIn};
  end

  assign validOut = validPipe[LAT-1];

  // R7: the valid flag is frozen during a stall
  assert_valid_stall_R7: assert property (@(posedge clk) disable iff (arst)
    !ctrl.adv |=> $stable(validOut));

endmodule

// File: rtl/sincos_stage.sv
module sincos_stage
  import sincos_pkg::*;
#(
  parameter int IW  = 19,
  parameter int GF  = 15,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 arst,
  input  logic                 adv,
  input  logic signed [IW-1:0] xIn,
  input  logic signed [IW-1:0] yIn,
  input  logic signed [IW-1:0] zIn,
  output logic signed [IW-1:0] xOut,
  output logic signed [IW-1:0] yOut,
  output logic signed [IW-1:0] zOut
);

  localparam logic signed [63:0]   ATAN_L = toFix(atanPow2(IDX), GF);
  localparam logic signed [IW-1:0] ATAN   = ATAN_L[IW-1:0];

  logic                 goDown;
  logic signed [IW-1:0] xSh, ySh;

  assign goDown = zIn[IW-1];
  assign xSh    = xIn >>> IDX;
  assign ySh    = yIn >>> IDX;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      xOut <= '0;
      yOut <= '0;
      zOut <= '0;
    end else if (adv) begin
      xOut <= goDown ? xIn + ySh  : xIn - ySh;
      yOut <= goDown ? yIn - xSh  : yIn + xSh;
      zOut <= goDown ? zIn + ATAN : zIn - ATAN;
    end
  end

endmodule

// File: rtl/sincos_datapath.sv
module sincos_datapath
  import sincos_pkg::*;
#(
  parameter  int FIN         = 12,
  parameter  int FOUT        = 10,
  parameter  bit SIGNED_MODE = 1'b1,
  localparam int AW          = SIGNED_MODE ? FIN + 3 : FIN + 1,
  localparam int OW          = SIGNED_MODE ? FOUT + 2 : FOUT + 1
) (
  input  logic          clk,
  input  logic          arst,
  input  ctrl_t         ctrl,
  input  logic [AW-1:0] angleIn,
  output logic [OW-1:0] sinOut,
  output logic [OW-1:0] cosOut
);

  localparam int N  = FOUT + 3;   // micro-rotations
  localparam int GF = FIN + 3;    // internal fraction bits
  localparam int IW = GF + 4;     // internal word
  localparam int SH = GF - FOUT;  // bits dropped at rounding

  localparam logic signed [63:0]   PI_L   = toFix(PI_R, GF);
  localparam logic signed [63:0]   HP_L   = toFix(PI_R / 2.0, GF);
  localparam logic signed [63:0]   INVK_L = toFix(INVK_R, GF);
  localparam logic signed [IW-1:0] PI_Q   = PI_L[IW-1:0];
  localparam logic signed [IW-1:0] HP_Q   = HP_L[IW-1:0];
  localparam logic signed [IW-1:0] INVK_Q = INVK_L[IW-1:0];
  localparam logic signed [IW-1:0] RND    = IW'(longint'(1) << (SH - 1));
  localparam logic signed [IW-1:0] ONE    = IW'(longint'(1) << FOUT);
  localparam logic signed [IW-1:0] LOW    = SIGNED_MODE ? -ONE : '0;
  localparam logic signed [IW-1:0] ZTOL   = IW'((longint'(1) << (GF - N + 2)) + N);
  localparam logic signed [IW-1:0] FTOL   = HP_Q + IW'(8);

  logic signed [IW-1:0] angleExt, zFold, zFoldQ;
  logic                 negFold;
  logic [N:0]           negPipe;
  logic signed [IW-1:0] xs [1:N];
  logic signed [IW-1:0] ys [1:N];
  logic signed [IW-1:0] zs [1:N];

  // Align the angle to the internal fraction width
  if (SIGNED_MODE) begin : gSignExt
    assign angleExt = {{(IW-AW-3){angleIn[AW-1]}}, angleIn, 3'b000};
  end else begin : gZeroExt
    assign angleExt = {{(IW-AW-3){1'b0}}, angleIn, 3'b000};
  end

  // Quadrant fold: bring the angle inside +-pi/2, remember to negate
  always_comb begin
    zFold   = angleExt;
    negFold = 1'b0;
    if (SIGNED_MODE) begin
      if (angleExt > HP_Q) begin
        zFold   = angleExt - PI_Q;
        negFold = 1'b1;
      end else if (angleExt < -HP_Q) begin
        zFold   = angleExt + PI_Q;
        negFold = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      zFoldQ  <= '0;
      negPipe <= '0;
    end else if (ctrl.adv) begin
      zFoldQ  <= zFold;
      negPipe <= {negPipe[N-1:0], negFold};
    end
  end

  // R5: the folded angle lies inside the convergence range
  assert_fold_range_R5: assert property (@(posedge clk) disable iff (arst)
    (zFoldQ <= FTOL) && (zFoldQ >= -FTOL));

  for (genvar k = 0; k < N; k++) begin : gStage
    logic signed [IW-1:0] xi, yi, zi;
    if (k == 0) begin : gFirst
      assign xi = INVK_Q;
      assign yi = '0;
      assign zi = zFoldQ;
    end else begin : gNext
      assign xi = xs[k];
      assign yi = ys[k];
      assign zi = zs[k];
    end
    sincos_stage #(.IW(IW), .GF(GF), .IDX(k)) uStage (
      .clk  (clk),
      .arst (arst),
      .adv  (ctrl.adv),
      .xIn  (xi),
      .yIn  (yi),
      .zIn  (zi),
      .xOut (xs[k+1]),
      .yOut (ys[k+1]),
      .zOut (zs[k+1])
    );
  end

  // R4: the residual angle after the last rotation is within one step
  assert_converge_R4: assert property (@(posedge clk) disable iff (arst)
    (zs[N] <= ZTOL) && (zs[N] >= -ZTOL));

  function automatic logic [OW-1:0] finishVal(input logic signed [IW-1:0] v,
                                              input logic neg);
    logic signed [IW-1:0] r;
    r = (v + RND) >>> SH;
    if (neg) r = -r;
    if (r > ONE)      r = ONE;
    else if (r < LOW) r = LOW;
    return r[OW-1:0];
  endfunction

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      sinOut <= '0;
      cosOut <= '0;
    end else if (ctrl.adv) begin
      sinOut <= finishVal(ys[N], negPipe[N]);
      cosOut <= finishVal(xs[N], negPipe[N]);
    end
  end

  // R7: results are frozen during a stall
  assert_data_stall_R7: assert property (@(posedge clk) disable iff (arst)
    !ctrl.adv |=> ($stable(sinOut) && $stable(cosOut)));

endmodule

// File: rtl/sincos_cordic.sv
module sincos_cordic
  import sincos_pkg::*;
#(
  parameter  int FIN         = 12,
  parameter  int FOUT        = 10,
  parameter  bit SIGNED_MODE = 1'b1,
  parameter  bit USE_EN      = 1'b1,
  localparam int AW          = SIGNED_MODE ? FIN + 3 : FIN + 1,
  localparam int OW          = SIGNED_MODE ? FOUT + 2 : FOUT + 1
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          clkEn,
  input  logic [AW-1:0] angleIn,
  input  logic          angleValid,
  output logic [OW-1:0] sinOut,
  output logic [OW-1:0] cosOut,
  output logic          resultValid
);

  localparam int LAT = FOUT + 5;

  ctrl_t ctrl;

  sincos_ctrl #(.LAT(LAT), .USE_EN(USE_EN)) uCtrl (
    .clk      (clk),
    .arst     (arst),
    .clkEn    (clkEn),
    .validIn  (angleValid),
    .ctrl     (ctrl),
    .validOut (resultValid)
  );

  sincos_datapath #(.FIN(FIN), .FOUT(FOUT), .SIGNED_MODE(SIGNED_MODE)) uPath (
    .clk     (clk),
    .arst    (arst),
    .ctrl    (ctrl),
    .angleIn (angleIn),
    .sinOut  (sinOut),
    .cosOut  (cosOut)
  );

  // R4: a valid pair lies close to the unit circle
  longint sVal, cVal, normDev, normTol;
  always_comb begin
    sVal    = SIGNED_MODE ? longint'($signed(sinOut)) : longint'({1'b0, sinOut});
    cVal    = SIGNED_MODE ? longint'($signed(cosOut)) : longint'({1'b0, cosOut});
    normDev = sVal * sVal + cVal * cVal - (longint'(1) << (2 * FOUT));
    normTol = (longint'(4) << FOUT) + 4;
  end

  assert_unit_circle_R4: assert property (@(posedge clk) disable iff (arst)
    resultValid |-> ((normDev <= normTol) && (normDev >= -normTol)));

endmodule

// File: tb/sim_sincos_cordic.sv
module sim_sincos_cordic;

  localparam int  FIN  = 12;
  localparam int  FOUT = 10;
  localparam int  AWS  = FIN + 3;
  localparam int  AWU  = FIN + 1;
  localparam int  OWS  = FOUT + 2;
  localparam int  OWU  = FOUT + 1;
  localparam int  LAT  = FOUT + 5;
  localparam real PIR  = 3.141592653589793;
  localparam real SIN_SC  = real'(1 << FIN);
  localparam real OUT_SC  = real'(1 << FOUT);
  localparam int  PI_C = int'(PIR * SIN_SC);
  localparam int  HP_C = int'(PIR / 2.0 * SIN_SC);

  typedef struct {
    real s;
    real c;
    int  t;
    bit  fold;
  } item_t;

  logic clk = 1'b0;
  logic arst = 1'b1;
  logic clkEn = 1'b0;
  logic [AWS-1:0] angS = '0;
  logic [AWU-1:0] angU = '0;
  logic vInS = 1'b0, vInU = 1'b0;
  logic [OWS-1:0] sinS, cosS;
  logic [OWU-1:0] sinU, cosU;
  logic vS, vU;

  int nChk = 0, nFail = 0;
  int tick = 0;
  bit lastAdv = 1'b0;
  bit done = 1'b0;
  item_t qS[$];
  item_t qU[$];

  always #4 clk = ~clk;   // 125 MHz

  sincos_cordic #(.FIN(FIN), .FOUT(FOUT), .SIGNED_MODE(1'b1)) u0 (
    .clk(clk), .arst(arst), .clkEn(clkEn), .angleIn(angS), .angleValid(vInS),
    .sinOut(sinS), .cosOut(cosS), .resultValid(vS));

  sincos_cordic #(.FIN(FIN), .FOUT(FOUT), .SIGNED_MODE(1'b0)) u1 (
    .clk(clk), .arst(arst), .clkEn(clkEn), .angleIn(angU), .angleValid(vInU),
    .sinOut(sinU), .cosOut(cosU), .resultValid(vU));

  task automatic checkInt(input string tag, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkNear(input string tag, input real act, input real exp);
    nChk++;
    if (act - exp > 1.0 || exp - act > 1.0) begin
      nFail++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
    end
  endtask

  task automatic checkTrue(input string tag, input bit ok, input longint act, input longint lim);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected within %0d", tag, act, lim);
    end
  endtask

  // Driver: one call per cycle, pushes expected items
  task automatic apply(input int sCode, input bit sv, input int uCode, input bit uv, input bit en);
    item_t it;
    real a;
    @(negedge clk);
    clkEn = en;
    angS  = sCode[AWS-1:0];
    vInS  = sv;
    angU  = uCode[AWU-1:0];
    vInU  = uv;
    if (en && sv) begin
      a = real'(sCode) / SIN_SC;
      it.s = $sin(a); it.c = $cos(a); it.t = tick;
      it.fold = (sCode > HP_C) || (sCode < -HP_C);
      qS.push_back(it);
    end
    if (en && uv) begin
      a = real'(uCode) / SIN_SC;
      it.s = $sin(a); it.c = $cos(a); it.t = tick; it.fold = 1'b0;
      qU.push_back(it);
    end
  endtask

  always @(posedge clk) begin
    if (arst) begin
      tick    <= 0;
      lastAdv <= 1'b0;
    end else begin
      if (clkEn) tick <= tick + 1;
      lastAdv <= clkEn;
    end
  end

  // Monitor: pops and compares as results come out
  logic [OWS-1:0] pSinS, pCosS;
  logic [OWU-1:0] pSinU, pCosU;
  logic pvS, pvU;
  bit havePrev = 1'b0;

  always @(negedge clk) begin
    item_t it;
    longint sa, ca;
    if (!arst) begin
      if (lastAdv) begin
        if (vS) begin
          if (qS.size() == 0) checkInt("R6 unexpected signed result", 1, 0);
          else begin
            it = qS.pop_front();
            sa = longint'($signed(sinS));
            ca = longint'($signed(cosS));
            checkInt("R6 signed latency", tick, it.t + LAT);
            checkNear(it.fold ? "R5,R4 signed sin" : "R2,R4 signed sin", real'(sa), it.s * OUT_SC);
            checkNear(it.fold ? "R5,R4 signed cos" : "R2,R4 signed cos", real'(ca), it.c * OUT_SC);
            checkTrue("R8 signed magnitude", (sa <= (1 << FOUT)) && (sa >= -(1 << FOUT)) &&
                      (ca <= (1 << FOUT)) && (ca >= -(1 << FOUT)), sa, 1 << FOUT);
          end
        end
        if (vU) begin
          if (qU.size() == 0) checkInt("R6 unexpected unsigned result", 1, 0);
          else begin
            it = qU.pop_front();
            sa = longint'({1'b0, sinU});
            ca = longint'({1'b0, cosU});
            checkInt("R6 unsigned latency", tick, it.t + LAT);
            checkNear("R3,R4 unsigned sin", real'(sa), it.s * OUT_SC);
            checkNear("R3,R4 unsigned cos", real'(ca), it.c * OUT_SC);
            checkTrue("R8 unsigned magnitude", (sa <= (1 << FOUT)) && (ca <= (1 << FOUT)),
                      ca, 1 << FOUT);
          end
        end
      end else if (havePrev) begin
        checkInt("R7 stall signed sin", sinS, pSinS);
        checkInt("R7 stall signed cos", cosS, pCosS);
        checkInt("R7 stall signed valid", vS, pvS);
        checkInt("R7 stall unsigned sin", sinU, pSinU);
        checkInt("R7 stall unsigned valid", vU, pvU);
      end
      pSinS = sinS; pCosS = cosS; pvS = vS;
      pSinU = sinU; pCosU = cosU; pvU = vU;
      havePrev = 1'b1;
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int bnd [12];
    // reset state
    repeat (3) @(negedge clk);
    checkInt("R1 reset signed valid", vS, 0);
    checkInt("R1 reset signed sin", sinS, 0);
    checkInt("R1 reset signed cos", cosS, 0);
    checkInt("R1 reset unsigned valid", vU, 0);
    checkInt("R1 reset unsigned cos", cosU, 0);
    @(negedge clk);
    arst = 1'b0;

    // boundary codes, back to back (R5, R8)
    bnd = '{0, 1, -1, HP_C, -HP_C, HP_C + 1, -HP_C - 1, HP_C - 1,
            PI_C, -PI_C, PI_C - 1, -PI_C + 1};
    for (int k = 0; k < 12; k++)
      apply(bnd[k], 1'b1, (k % 4 == 0) ? 0 : (k % 4 == 1) ? 1 : (k % 4 == 2) ? HP_C - 1 : HP_C,
            1'b1, 1'b1);

    // full-range sweep
    for (int k = 0; k < 200; k++)
      apply(-PI_C + (k * 2 * PI_C) / 199, 1'b1, (k * HP_C) / 199, 1'b1, 1'b1);

    // random stalls, bubbles and angles (R7, R6)
    for (int k = 0; k < 600; k++)
      apply(int'($urandom_range(2 * PI_C)) - PI_C, ($urandom % 4) != 0,
            int'($urandom_range(HP_C)), ($urandom % 3) != 0, ($urandom % 3) != 0);

    // drain
    for (int k = 0; k < LAT + 5; k++) apply(0, 1'b0, 0, 1'b0, 1'b1);
    checkInt("R6 signed results outstanding", qS.size(), 0);
    checkInt("R6 unsigned results outstanding", qU.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule